// File: doc/BRIEF.md
# Gamma Lookup Table Unit

This block applies per-channel gamma correction to a stream of 24-bit RGB pixels in a display pixel path. Each colour channel has its own 256-entry table of 8-bit output values. An incoming pixel's red, green and blue values each select an entry in their own channel's table. The three looked-up values leave the block one clock later, together with a delayed valid flag.

Software loads the tables through a single 32-bit write port. Each write word carries the target entry index in its top byte and the three channel values in the lower three bytes, so a full table load is 256 back-to-back writes to the same port. The block holds two banks. With shadowing switched off, writes land directly in the bank that is serving pixels. With shadowing switched on, writes go to the idle bank. Software then raises a commit request, and the banks swap at the next frame-start pulse, so a frame never mixes two curves.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset, both banks hold the identity ramp (entry i holds i in every channel), `pix_valid_o` is 0 and `pix_o` is 0.
- R2: `pix_valid_o` equals `pix_valid_i` delayed by one cycle. When `pix_valid_i` is low, `pix_o` keeps its previous value.
- R3: In a write word, bits 31:24 give the entry index, bits 23:16 the red value, bits 15:8 the green value and bits 7:0 the blue value.
- R4: With `shadow_en` low, a write updates the active bank. A pixel presented in the following cycle sees the new entry.
- R5: With `shadow_en` high, a write updates only the idle bank and does not change any pixel result before a swap.
- R6: A `commit_req` with `shadow_en` high arms a pending swap. The banks swap on the first later cycle in which `frame_start` is high. A `frame_start` with no pending swap changes nothing.
- R7: A `commit_req` in the same cycle as `frame_start` is not acted on by that pulse. A `commit_req` while `shadow_en` is low is ignored.
- R8: Results use the table contents from before the clock edge. A pixel in the swap cycle uses the old bank, and a pixel in the same cycle as a write to its entry gets the old value.
- R9: After a swap, the formerly active bank becomes the idle bank, and it is the target of shadowed writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_data | input | 32 | Write word: index and three channel values |
| shadow_en | input | 1 | 1 = writes target the idle bank |
| commit_req | input | 1 | Request a bank swap at the next frame start |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_i | input | 24 | Input pixel, red 23:16, green 15:8, blue 7:0 |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Corrected pixel, same channel layout |

## Verification
Every pixel result is due exactly one clock after the pixel is presented. A table write or a bank swap is first visible to a pixel presented in the cycle after the write or the frame-start pulse. The bench drives all inputs on the falling edge and checks the outputs on the next falling edge. Its reference model is updated only after the expected result has been taken from the pre-edge table state, which gives the read-before-write and swap-cycle results of R8. The held-output rule is checked by comparing `pix_o` on every cycle, including cycles where valid is low.

// File: rtl/gamma_lut_pkg.sv
// Shared constants for the gamma lookup stage.
// Assumes three colour channels of equal width; the table depth follows
// from the channel width because a channel value is the table index.
package gamma_lut_pkg;
    localparam int NUM_CH = 3;
    localparam int CH_BLUE  = 0;
    localparam int CH_GREEN = 1;
    localparam int CH_RED   = 2;
endpackage

// File: rtl/gamma_wr_decode.sv
// Splits a table write word into entry index and per-channel values.
// Assumes the index sits above the channel fields and blue is lowest.
module gamma_wr_decode
    import gamma_lut_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic [(NUM_CH+1)*CH_W-1:0]   wr_data,
    output logic [CH_W-1:0]              wr_idx,
    output logic [NUM_CH-1:0][CH_W-1:0]  wr_val
);
    localparam int IDX_LSB = NUM_CH * CH_W;

    // Index field from the top of the word.
    assign wr_idx = wr_data[IDX_LSB +: CH_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // One channel value per field.
        assign wr_val[c] = wr_data[c*CH_W +: CH_W];
    end
endmodule

// File: rtl/gamma_bank_ctrl.sv
// Tracks which bank serves pixels, the pending commit, and the write target.
// Assumes frame_start is a single-cycle pulse; a commit arms only in shadow mode.
module gamma_bank_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic shadow_en,
    input  logic commit_req,
    input  logic frame_start,
    output logic act_sel,
    output logic commit_pend,
    output logic wr_bank
);
    logic swap;

    // A swap needs a commit armed before this frame-start pulse.
    assign swap = frame_start && commit_pend;

    // Shadow writes target the idle bank, direct writes the active bank.
    assign wr_bank = shadow_en ? ~act_sel : act_sel;

    // Active bank flips on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_sel <= 1'b0;
        else if (swap) act_sel <= ~act_sel;
    end

    // Commit flag: set by a shadowed request, cleared by the swap it causes.
    always_ff @(posedge clk) begin
        if (!rst_n)                        commit_pend <= 1'b0;
        else if (commit_req && shadow_en)  commit_pend <= 1'b1;
        else if (swap)                     commit_pend <= 1'b0;
    end
endmodule

// File: rtl/gamma_chan_table.sv
// Two-bank lookup table for one colour channel with a registered read.
// Assumes read and write to the same entry in one cycle return the old value.
module gamma_chan_table #(
    parameter int CH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_bank,
    input  logic [CH_W-1:0] wr_idx,
    input  logic [CH_W-1:0] wr_val,
    input  logic            rd_en,
    input  logic            rd_bank,
    input  logic [CH_W-1:0] rd_idx,
    output logic [CH_W-1:0] rd_q
);
    localparam int DEPTH = 1 << CH_W;

    logic [CH_W-1:0] mem [2][DEPTH];

    // Table storage: identity ramp on reset, else single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[b][i] <= CH_W'(i);
                end
            end
        end else if (wr_en) begin
            mem[wr_bank][wr_idx] <= wr_val;
        end
    end

    // Registered lookup, held while no pixel is presented.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[rd_bank][rd_idx];
    end
endmodule

// File: rtl/gamma_lut_stage.sv
// Gamma correction stage: per-channel table lookup with shadowed loading.
// Assumes pixel channels are packed red high, blue low; results lag by one cycle.
module gamma_lut_stage
    import gamma_lut_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [(NUM_CH+1)*CH_W-1:0]  wr_data,
    input  logic                        shadow_en,
    input  logic                        commit_req,
    input  logic                        frame_start,
    input  logic                        pix_valid_i,
    input  logic [NUM_CH*CH_W-1:0]      pix_i,
    output logic                        pix_valid_o,
    output logic [NUM_CH*CH_W-1:0]      pix_o
);
    logic                       act_sel;
    logic                       commit_pend;
    logic                       wr_bank;
    logic [CH_W-1:0]            wr_idx;
    logic [NUM_CH-1:0][CH_W-1:0] wr_val;

    gamma_wr_decode #(.CH_W(CH_W)) u_dec (
        .wr_data (wr_data),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val)
    );

    gamma_bank_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .shadow_en   (shadow_en),
        .commit_req  (commit_req),
        .frame_start (frame_start),
        .act_sel     (act_sel),
        .commit_pend (commit_pend),
        .wr_bank     (wr_bank)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_tab
        gamma_chan_table #(.CH_W(CH_W)) u_tab (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_bank (wr_bank),
            .wr_idx  (wr_idx),
            .wr_val  (wr_val[c]),
            .rd_en   (pix_valid_i),
            .rd_bank (act_sel),
            .rd_idx  (pix_i[c*CH_W +: CH_W]),
            .rd_q    (pix_o[c*CH_W +: CH_W])
        );
    end

    // Valid follows the pixel through the one-cycle lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_valid_o <= 1'b0;
        else        pix_valid_o <= pix_valid_i;
    end
endmodule

// File: rtl/gamma_lut_chk.sv
// Protocol checks for the gamma stage, bound to the top module.
// Assumes access to the active-bank select and commit flag of the top.
module gamma_lut_chk #(
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid_i,
    input logic          pix_valid_o,
    input logic [PW-1:0] pix_o,
    input logic          shadow_en,
    input logic          commit_req,
    input logic          frame_start,
    input logic          act_sel,
    input logic          commit_pend
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o);
    a_r2_invalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> !pix_valid_o);
    a_r2_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid_i |=> $stable(pix_o));
    a_r6_swap_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && commit_pend) |=> (act_sel != $past(act_sel)));
    a_r6_no_stray_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && commit_pend) |=> $stable(act_sel));
    a_r7_commit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !shadow_en && !commit_pend) |=> !commit_pend);
    a_r6_commit_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && shadow_en) |=> commit_pend);
endmodule

bind gamma_lut_stage gamma_lut_chk #(.PW(24)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid_i (pix_valid_i),
    .pix_valid_o (pix_valid_o),
    .pix_o       (pix_o),
    .shadow_en   (shadow_en),
    .commit_req  (commit_req),
    .frame_start (frame_start),
    .act_sel     (act_sel),
    .commit_pend (commit_pend)
);

// File: tb/gamma_lut_stage_tb.sv
`timescale 1ns/1ps
module gamma_lut_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        shadow_en = 1'b0;
    logic        commit_req = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [23:0] pix_i = '0;
    logic        pix_valid_o;
    logic [23:0] pix_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [23:0] bm [2][256];
    bit          m_act, m_pend;
    logic [23:0] exp_pix;
    bit          exp_v;

    always #2 clk = ~clk;

    gamma_lut_stage u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .shadow_en(shadow_en), .commit_req(commit_req), .frame_start(frame_start),
        .pix_valid_i(pix_valid_i), .pix_i(pix_i),
        .pix_valid_o(pix_valid_o), .pix_o(pix_o)
    );

    function automatic logic [23:0] lookup(input logic [23:0] p);
        return {bm[m_act][p[23:16]][23:16], bm[m_act][p[15:8]][15:8], bm[m_act][p[7:0]][7:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, model, check at next falling edge.
    task automatic cyc(input bit we, input logic [31:0] wd, input bit sh, input bit cm,
                       input bit fs, input bit pv, input logic [23:0] px, input string tag);
        bit bk, sw;
        wr_en = we; wr_data = wd; shadow_en = sh; commit_req = cm;
        frame_start = fs; pix_valid_i = pv; pix_i = px;
        if (pv) exp_pix = lookup(px);
        exp_v = pv;
        if (we) begin
            bk = sh ? ~m_act : m_act;
            bm[bk][wd[31:24]] = wd[23:0];
        end
        sw = fs && m_pend;
        if (cm && sh) m_pend = 1;
        else if (sw)  m_pend = 0;
        if (sw) m_act = ~m_act;
        @(negedge clk);
        check(pix_valid_o == exp_v, {tag, " valid"}, {23'd0, pix_valid_o}, {23'd0, exp_v});
        check(pix_o == exp_pix, {tag, " pixel"}, pix_o, exp_pix);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++) bm[b][i] = {3{8'(i)}};
        m_act = 0; m_pend = 0; exp_pix = '0; exp_v = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        check(pix_o == 24'd0 && pix_valid_o == 1'b0, "R1 reset", pix_o, 24'd0);
        // R1: identity ramp serves pixels unchanged
        cyc(0, 0, 0, 0, 0, 1, 24'h00FF80, "R1 identity");
        cyc(0, 0, 0, 0, 0, 1, 24'h7F0132, "R1 identity");
        // R3 / R4: direct write, fields per channel
        cyc(1, 32'h10112233, 0, 0, 0, 0, 24'h0, "R4 write");
        cyc(0, 0, 0, 0, 0, 1, 24'h101010, "R3 fields");
        cyc(0, 0, 0, 0, 0, 1, 24'h100000, "R3 red only");
        cyc(0, 0, 0, 0, 0, 1, 24'h000010, "R4 blue only");
        // R8: write and read same entry in one cycle
        cyc(1, 32'h20A0B0C0, 0, 0, 0, 1, 24'h202020, "R8 old value");
        cyc(0, 0, 0, 0, 0, 1, 24'h202020, "R4 new value");
        // R2: valid low holds output
        cyc(0, 0, 0, 0, 0, 0, 24'h555555, "R2 hold");
        cyc(0, 0, 0, 0, 0, 0, 24'hAAAAAA, "R2 hold");
        // R5: shadow write leaves active bank alone
        cyc(1, 32'h30DEADBE, 1, 0, 0, 1, 24'h303030, "R5 shadow");
        cyc(0, 0, 1, 0, 0, 1, 24'h303030, "R5 shadow");
        // R6: frame start without commit does nothing
        cyc(0, 0, 1, 0, 1, 1, 24'h303030, "R6 no commit");
        cyc(0, 0, 1, 0, 0, 1, 24'h303030, "R6 no commit");
        // R7: commit with frame start in same cycle does not swap
        cyc(0, 0, 1, 1, 1, 1, 24'h303030, "R7 same cycle");
        cyc(0, 0, 1, 0, 0, 1, 24'h303030, "R7 same cycle");
        // R8: pixel in swap cycle uses old bank; R6 swap visible next
        cyc(0, 0, 1, 0, 1, 1, 24'h303030, "R8 swap cycle");
        cyc(0, 0, 1, 0, 0, 1, 24'h303030, "R6 swapped");
        cyc(0, 0, 1, 0, 0, 1, 24'h101010, "R9 old bank idle");
        // R7: commit while shadow off is ignored
        cyc(0, 0, 0, 1, 0, 1, 24'h303030, "R7 ignored");
        cyc(0, 0, 0, 0, 1, 1, 24'h303030, "R7 ignored");
        cyc(0, 0, 0, 0, 0, 1, 24'h303030, "R7 ignored");
        // R9: shadow write now targets the former active bank
        cyc(1, 32'h10445566, 1, 1, 0, 1, 24'h101010, "R9 shadow");
        cyc(0, 0, 1, 0, 1, 1, 24'h101010, "R9 swap");
        cyc(0, 0, 1, 0, 0, 1, 24'h101010, "R9 new");
        cyc(0, 0, 1, 0, 0, 1, 24'h202020, "R9 kept");
        // R2: random mix
        void'($urandom(32'd24681));
        for (int k = 0; k < 4000; k++) begin
            bit sh, we, cm, fs, pv;
            sh = (k / 250) % 2 == 1;
            we = ($urandom % 100) < 30;
            cm = ($urandom % 100) < 3;
            fs = ($urandom % 100) < 2;
            pv = ($urandom % 100) < 70;
            cyc(we, $urandom, sh, cm, fs, pv, 24'($urandom), "R2 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule